// File: doc/BRIEF.md
# Pipelined BCD Phase Accumulator

This block keeps a running phase in decimal. Every clock it adds a frequency word to its phase, plus an optional carry-in bit. The frequency word is packed BCD: eight 4-bit decades and a 3-bit top digit. The phase therefore wraps at 800,000,000 rather than at a power of two. With an 80 MHz clock, one unit of the word then equals exactly 0.1 Hz of output frequency.

The adder is split into stages of three digits each, with a registered carry between stages. Skew registers on the word inputs and deskew registers on the sums make the result equal to a plain modulo adder whose output is delayed by a fixed two cycles. A new word reaches every digit stage in the same aligned cycle, so a frequency change is phase-continuous.

The phase output is a continuous stream of one sample per clock. It has no valid or ready pair and takes no back-pressure: a consumer has to accept every sample. The load strobe and the carry-in are plain control pins.

Top module: `bcd_phase_accum`

## Requirements
- R1: Nibble k of `freq_i` (bits 4k+3..4k, k = 0..7) is one 8-4-2-1 BCD decade of weight 10^k. Bits 34..32 are the top digit, of weight 10^8 and range 0..7.
- R2: A decade nibble with a value above 9 is taken as 9 when the word is loaded.
- R3: `phase_o` is floor(phase / 100000), an index from 0 to 7999. Bits 14..12 hold its top digit (thousands), and bits 11..8, 7..4 and 3..0 hold its hundreds, tens and units as BCD. Each of those decades is always 9 or less.
- R4: On every clock edge out of reset, phase becomes (phase + word + carry-in) mod 800,000,000. Any overflow out of the top digit is discarded.
- R5: `cin_i` = 1 adds one extra unit in that cycle, exactly as if the word were one larger.
- R6: The word register takes the clamped `freq_i` on an edge where `load_i` = 1. When `load_i` = 0 it holds its value, and changes on `freq_i` have no effect.
- R7: The output after edge n shows the phase reached at edge n-2. A word loaded at edge k is first added at edge k+1, at all digits at once.
- R8: `rst_ni` low clears the word register and the phase at once, without waiting for a clock edge. `phase_o` is 0 during reset and at the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_i | input | 35 | BCD frequency word |
| load_i | input | 1 | Load strobe for the word register |
| cin_i | input | 1 | Carry into the least significant digit |
| phase_o | output | 15 | Top four digits of the phase, BCD |

## Verification
A wrong carry between stages, or a lost skew register, moves the phase index by whole units. It shows at `phase_o` within two cycles of the first step whose carry crosses the faulty boundary. A clamping fault or a load-timing fault shows as a wrong per-cycle increment of the index from the cycle after the load. Large words are used to expose these faults, because they make the four visible digits move every cycle. Wrap faults are exposed by stepping across 799,999,999, which gives a jump to index 7999.

// File: rtl/bcdacc_pkg.sv
package bcdacc_pkg;
  localparam int DIG_W = 4;
  localparam logic [DIG_W-1:0] DEC_MAX = 4'd9;

  function automatic logic [DIG_W-1:0] clamp_decade(input logic [DIG_W-1:0] n);
    return (n > DEC_MAX) ? DEC_MAX : n;
  endfunction
endpackage

// File: rtl/bcdacc_digit_add.sv
module bcdacc_digit_add #(
  parameter int RADIX = 10
) (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       c_i,
  output logic [3:0] s_o,
  output logic       c_o
);
  logic [4:0] raw;

  always_comb begin
    raw = {1'b0, a_i} + {1'b0, b_i} + {4'b0, c_i};
    if (raw >= 5'(RADIX)) begin
      s_o = 4'(raw - 5'(RADIX));
      c_o = 1'b1;
    end else begin
      s_o = raw[3:0];
      c_o = 1'b0;
    end
  end
endmodule

// File: rtl/bcdacc_delay.sv
module bcdacc_delay #(
  parameter int W     = 4,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    logic unused_clk_rst;
    assign unused_clk_rst = clk_i ^ rst_ni;
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] pipe [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
      end else begin
        pipe[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
      end
    end
    assign q_o = pipe[DEPTH-1];
  end
endmodule

// File: rtl/bcdacc_stage.sv
module bcdacc_stage #(
  parameter int CNT       = 3,
  parameter bit HAS_TOP   = 1'b0,
  parameter int TOP_RADIX = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT*4-1:0] add_i,
  input  logic             c_i,
  output logic [CNT*4-1:0] sum_o,
  output logic             c_o
);
  logic [CNT:0]     chain;
  logic [CNT*4-1:0] nxt;

  assign chain[0] = c_i;

  for (genvar d = 0; d < CNT; d++) begin : g_dig
    localparam int RDX = (HAS_TOP && d == CNT - 1) ? TOP_RADIX : 10;
    bcdacc_digit_add #(.RADIX(RDX)) u_add (
      .a_i(sum_o[d*4 +: 4]),
      .b_i(add_i[d*4 +: 4]),
      .c_i(chain[d]),
      .s_o(nxt[d*4 +: 4]),
      .c_o(chain[d+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      c_o   <= 1'b0;
    end else begin
      sum_o <= nxt;
      c_o   <= chain[CNT];
    end
  end
endmodule

// File: rtl/bcd_phase_accum.sv
module bcd_phase_accum
  import bcdacc_pkg::*;
#(
  parameter int DEC_DIGITS     = 8,
  parameter int TOP_W          = 3,
  parameter int DIGS_PER_STAGE = 3,
  parameter int OUT_DECADES    = 3,
  localparam int WORD_W = DEC_DIGITS * 4 + TOP_W,
  localparam int OUT_W  = TOP_W + 4 * OUT_DECADES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] freq_i,
  input  logic              load_i,
  input  logic              cin_i,
  output logic [OUT_W-1:0]  phase_o
);
  localparam int NDIG      = DEC_DIGITS + 1;
  localparam int NSTAGE    = (NDIG + DIGS_PER_STAGE - 1) / DIGS_PER_STAGE;
  localparam int LAT       = NSTAGE - 1;
  localparam int ACC_W     = NDIG * 4;
  localparam int TOP_RADIX = 1 << TOP_W;
  localparam int OUT_LO    = (NDIG - 1 - OUT_DECADES) * 4;

  logic [ACC_W-1:0]  word_clamped;
  logic [ACC_W-1:0]  word_q;
  logic [ACC_W-1:0]  acc_al;
  logic [NSTAGE-1:0] carry;
  logic              unused_phase_bits;

  // Clamp each decade on the way in; the top digit is used as given.
  always_comb begin
    word_clamped = '0;
    for (int k = 0; k < DEC_DIGITS; k++)
      word_clamped[k*4 +: 4] = clamp_decade(freq_i[k*4 +: 4]);
    word_clamped[DEC_DIGITS*4 +: TOP_W] = freq_i[DEC_DIGITS*4 +: TOP_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_clamped;
  end

  assign carry[0] = cin_i;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int LO   = s * DIGS_PER_STAGE;
    localparam int CNT  = (NDIG - LO < DIGS_PER_STAGE) ? (NDIG - LO) : DIGS_PER_STAGE;
    localparam bit LAST = (s == NSTAGE - 1);

    logic [CNT*4-1:0] add_skew;
    logic [CNT*4-1:0] sum_raw;
    logic             co;

    // Stage s works s cycles behind stage 0, so its word slice is delayed by s.
    bcdacc_delay #(.W(CNT*4), .DEPTH(s)) u_skew (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .d_i(word_q[LO*4 +: CNT*4]), .q_o(add_skew)
    );

    bcdacc_stage #(.CNT(CNT), .HAS_TOP(LAST), .TOP_RADIX(TOP_RADIX)) u_stage (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .add_i(add_skew), .c_i(carry[s]),
      .sum_o(sum_raw), .c_o(co)
    );

    if (!LAST) begin : g_fwd
      assign carry[s+1] = co;
    end else begin : g_wrap
      logic unused_wrap_carry;
      assign unused_wrap_carry = co;
    end

    // Realign so that every group shows the same accumulated sum.
    bcdacc_delay #(.W(CNT*4), .DEPTH(LAT - s)) u_deskew (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .d_i(sum_raw), .q_o(acc_al[LO*4 +: CNT*4])
    );
  end

  assign phase_o = {acc_al[(NDIG-1)*4 +: TOP_W], acc_al[OUT_LO +: OUT_DECADES*4]};
  assign unused_phase_bits = ^acc_al;
endmodule

// File: rtl/bcd_phase_accum_chk.sv
module bcd_phase_accum_chk #(
  parameter int DEC_DIGITS     = 8,
  parameter int TOP_W          = 3,
  parameter int DIGS_PER_STAGE = 3,
  parameter int OUT_DECADES    = 3,
  localparam int WORD_W = DEC_DIGITS * 4 + TOP_W,
  localparam int OUT_W  = TOP_W + 4 * OUT_DECADES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] freq_i,
  input logic              load_i,
  input logic              cin_i,
  input logic [OUT_W-1:0]  phase_o
);
  function automatic longint pow10(input int n);
    longint p = 1;
    for (int i = 0; i < n; i++) p = p * 10;
    return p;
  endfunction

  localparam int     NDIG    = DEC_DIGITS + 1;
  localparam int     NSTAGE  = (NDIG + DIGS_PER_STAGE - 1) / DIGS_PER_STAGE;
  localparam int     LAT     = NSTAGE - 1;
  localparam longint MODULUS = longint'(1 << TOP_W) * pow10(DEC_DIGITS);
  localparam longint DIV     = pow10(DEC_DIGITS - OUT_DECADES);

  function automatic longint word_value(input logic [WORD_W-1:0] w);
    longint v = 0;
    longint p = 1;
    for (int k = 0; k < DEC_DIGITS; k++) begin
      logic [3:0] d = w[k*4 +: 4];
      if (d > 4'd9) d = 4'd9;
      v = v + longint'(d) * p;
      p = p * 10;
    end
    return v + longint'(w[DEC_DIGITS*4 +: TOP_W]) * p;
  endfunction

  longint      m_word;
  longint      m_hist [LAT+2];
  logic [31:0] cyc;
  longint      phase_num;
  logic        digits_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_word <= 0;
      for (int i = 0; i < LAT + 2; i++) m_hist[i] <= 0;
      cyc <= '0;
    end else begin
      m_hist[0] <= (m_hist[0] + m_word + longint'(cin_i)) % MODULUS;
      for (int i = 1; i < LAT + 2; i++) m_hist[i] <= m_hist[i-1];
      if (load_i) m_word <= word_value(freq_i);
      if (cyc != '1) cyc <= cyc + 1;
    end
  end

  always_comb begin
    phase_num = longint'(phase_o[OUT_W-1 -: TOP_W]);
    digits_ok = 1'b1;
    for (int k = OUT_DECADES - 1; k >= 0; k--) begin
      phase_num = phase_num * 10 + longint'(phase_o[k*4 +: 4]);
      if (phase_o[k*4 +: 4] > 4'd9) digits_ok = 1'b0;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 0) |-> (phase_o == '0)); // R8
  AST_DECADE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digits_ok); // R3
  AST_MODEL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_num == m_hist[LAT] / DIV); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 0 && m_hist[LAT] == m_hist[LAT+1]) |-> $stable(phase_o)); // R7
endmodule

bind bcd_phase_accum bcd_phase_accum_chk #(
  .DEC_DIGITS(DEC_DIGITS), .TOP_W(TOP_W),
  .DIGS_PER_STAGE(DIGS_PER_STAGE), .OUT_DECADES(OUT_DECADES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .freq_i(freq_i),
  .load_i(load_i), .cin_i(cin_i), .phase_o(phase_o)
);

// File: tb/test_bcd_phase_accum.sv
module test_bcd_phase_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [34:0] freq = '0;
  logic        load = 1'b0;
  logic        cin = 1'b0;
  logic [14:0] phase;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  longint b_word = 0;
  longint h0 = 0, h1 = 0, h2 = 0;

  always #2 clk = ~clk;

  bcd_phase_accum i_bcd_phase_accum (
    .clk_i(clk), .rst_ni(rst_n), .freq_i(freq),
    .load_i(load), .cin_i(cin), .phase_o(phase)
  );

  function automatic longint sat_val(input logic [34:0] w);
    longint v = 0;
    longint p = 1;
    for (int k = 0; k < 8; k++) begin
      longint d = longint'(w[k*4 +: 4]);
      if (d > 9) d = 9;
      v = v + d * p;
      p = p * 10;
    end
    return v + longint'(w[34:32]) * p;
  endfunction

  function automatic logic [14:0] exp_phase(input longint a);
    longint v = a / 100000;
    return {3'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  // Reference: plain modulo adder, output shown two edges later.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_word = 0; h0 = 0; h1 = 0; h2 = 0;
    end else begin
      h2 = h1;
      h1 = h0;
      h0 = (h0 + b_word + longint'(cin)) % 64'd800000000;
      if (load) b_word = sat_val(freq);
    end
  end

  task automatic chk(input string req);
    logic [14:0] e = exp_phase(h2);
    vectors++;
    if (phase !== e) begin
      fails++;
      $display("FAIL %s: phase_o=%h expected %h", req, phase, e);
    end
  endtask

  task automatic step(input logic [34:0] f, input logic ld, input logic ci, input string req);
    @(negedge clk);
    chk(req);
    freq = f; load = ld; cin = ci;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R8 during reset");
    rst_n = 1'b1;
    step('0, 1'b0, 1'b0, "R8 after release");
    step('0, 1'b0, 1'b0, "R8 first edge");

    // R1 R7: one unit of index per cycle, appearing after the load latency
    step(35'h0_0010_0000, 1'b1, 1'b0, "R7 load");
    for (int i = 0; i < 12; i++) step(35'h0_0010_0000, 1'b0, 1'b0, "R1 R7 unit step");

    // R1 R3: mixed digits
    step(35'h1_2345_6789, 1'b1, 1'b0, "R1 load mixed");
    for (int i = 0; i < 40; i++) step(35'h1_2345_6789, 1'b0, 1'b0, "R3 mixed digits");

    // R5: 99999 plus carry-in acts as 100000
    step(35'h0_0009_9999, 1'b1, 1'b1, "R5 load");
    for (int i = 0; i < 20; i++) step(35'h0_0009_9999, 1'b0, 1'b1, "R5 carry in");
    for (int i = 0; i < 20; i++) step(35'h0_0009_9999, 1'b0, 1'b0, "R5 carry off");

    // R2: decade 5 = F is taken as 9
    step(35'h0_00F0_0000, 1'b1, 1'b0, "R2 load");
    for (int i = 0; i < 20; i++) step(35'h0_00F0_0000, 1'b0, 1'b0, "R2 saturation");

    // R4: largest word steps backwards, wrapping through 799,999,999
    rst_n = 1'b0;
    #1 chk("R8 async clear");
    @(negedge clk) rst_n = 1'b1;
    step(35'h7_9999_9999, 1'b1, 1'b0, "R4 load max");
    for (int i = 0; i < 20; i++) step(35'h7_9999_9999, 1'b0, 1'b0, "R4 wrap");
    for (int i = 0; i < 20; i++) step(35'h7_FFFF_FFFF, i == 0, 1'b0, "R2 R4 all F");

    // R6: changing freq without load has no effect
    step(35'h0_0020_0000, 1'b1, 1'b0, "R6 load");
    for (int i = 0; i < 30; i++)
      step({3'($urandom_range(0, 7)), 32'($urandom)}, 1'b0, 1'b0, "R6 ignored");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [34:0] f;
      f = {3'($urandom_range(0, 7)), 32'($urandom)};
      step(f, ($urandom_range(0, 9) < 3), ($urandom_range(0, 9) == 0), "R4 R5 R6 R7 random");
    end
    step('0, 1'b0, 1'b0, "R4 final");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule